// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a small synchronous SRAM. Reads and writes can be mixed freely on consecutive clocks with no idle cycle between them. Address and control are captured on the rising clock edge, together with three chip selects, per-lane write strobes, a load/advance control and a burst-order choice.

Read data is not registered on the way out. Once an edge has registered a read address, the word appears combinationally on the data output during the cycle that follows. A write works differently: its address and strobes are taken at one edge, and its data is taken at the next enabled edge. The array is updated at that second edge. Because of this split, a write followed directly by a read still moves one word on every clock.

A clock-enable input freezes the whole pipeline. A burst sequencer steps the two low address bits in either linear or interleaved order. The output bus is modelled as a value plus a drive-enable. That drive-enable is gated by an asynchronous output enable.

Top module: `flowSram`

## Requirements
- R1: When `clkEn` is 1, the inputs `addr`, `selA`, `selBN`, `selC`, `wrEn`, `laneWe`, `advLoad` and `burstIlv` are captured on the rising edge of `clk`. A load (`advLoad`=0) with `wrEn`=0 is a read, and with `wrEn`=1 it is a write.
- R2: A rising edge with `clkEn`=0 has no effect. No write commits, the burst does not advance, and `dOut`/`dOutEn` keep their values.
- R3: After the edge that registers a selected read of address A, `dOutEn` is 1 (when `oe`=1) and `dOut` equals the word at A. Both hold during the same cycle, before the next edge.
- R4: Write data on `dIn` is taken at the next enabled edge after the edge that registered the write, and it is committed at that edge. A read registered at that same edge returns the new data.
- R5: Bit i of `laneWe` lets a write update bits [9i+8:9i] of the word. Lanes whose bit is 0 keep their old contents.
- R6: A load is selected only when `selA`=1, `selBN`=0 and `selC`=1. Any other combination is a deselect: `dOutEn` is 0 and no write happens.
- R7: While a registered write is waiting for its data, `dOutEn` is 0.
- R8: When `oe`=0, `dOutEn` goes to 0 at once, with no clock edge needed.
- R9: An advance (`advLoad`=1) repeats the operation type of the burst. It ignores `wrEn` and the selects, and it keeps the upper address bits. In linear order the low two bits are (start + count) mod 4.
- R10: `burstIlv` is captured at load: 1 selects interleaved order and 0 selects linear order. In interleaved order the low two bits are the start bits XOR count. `burstIlv` is ignored during an advance.
- R11: An advance that follows a deselect is also a deselect.
- R12: While `rstN`=0 and after it is released, the block is deselected and `dOutEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock qualifier, 1 = edge takes effect |
| addr | input | ADDR_W | Word address for a load |
| selA | input | 1 | Chip select, active high |
| selBN | input | 1 | Chip select, active low |
| selC | input | 1 | Chip select, active high |
| wrEn | input | 1 | 1 = write, 0 = read (on load) |
| laneWe | input | LANES | Per-lane write strobes |
| advLoad | input | 1 | 0 = load new address, 1 = advance burst |
| burstIlv | input | 1 | 1 = interleaved order, 0 = linear (on load) |
| oe | input | 1 | Asynchronous output enable |
| dIn | input | LANES*LANE_W | Write data |
| dOut | output | LANES*LANE_W | Read data (zero when not driving) |
| dOutEn | output | 1 | Output driver enable |

## Verification
Read results are due in the same cycle as the edge that registers the read address. The bench therefore drives inputs at the falling edge, waits for the rising edge, and samples 1 ns later, before the next falling edge. Write data belongs to the step after the write command, so each write is checked by reading the word back in a later step. The read-after-write case puts the read in the very step that carries the write data. Stall checks compare the outputs one stalled edge later against the values held before that edge. The output-enable check changes `oe` between edges and samples without any clock.

// File: rtl/sramPkg.sv
package sramPkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burstOrder_t;

  typedef struct packed {
    logic commit;      // write data is taken at this edge
    logic readPhase;   // a selected read is registered
    logic writePhase;  // a selected write awaits its data
  } ctrlStrobes_t;

endpackage

// File: rtl/sramBurstSeq.sv
module sramBurstSeq
  import sramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        count,
  input  burstOrder_t       order,
  output logic [ADDR_W-1:0] seqAddr
);

  logic [1:0] lowLinear;
  logic [1:0] lowInterleaved;

  always_comb begin
    lowLinear      = baseAddr[1:0] + count;
    lowInterleaved = baseAddr[1:0] ^ count;
    seqAddr        = {baseAddr[ADDR_W-1:2],
                      (order == ORDER_INTERLEAVED) ? lowInterleaved : lowLinear};
  end

endmodule

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selA,
  input  logic              selBN,
  input  logic              selC,
  input  logic              wrEn,
  input  logic [LANES-1:0]  laneWe,
  input  logic              advLoad,
  input  logic              burstIlv,
  output ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LANES-1:0]  curLanes
);

  logic              curValid;
  logic              curWrite;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        cnt;
  burstOrder_t       order;
  logic              chipSelected;

  assign chipSelected = selA & ~selBN & selC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValid <= 1'b0;
      curWrite <= 1'b0;
      baseAddr <= '0;
      cnt      <= '0;
      order    <= ORDER_LINEAR;
      curLanes <= '0;
    end else if (clkEn) begin
      curLanes <= laneWe;
      if (!advLoad) begin
        curValid <= chipSelected;
        curWrite <= wrEn;
        baseAddr <= addr;
        cnt      <= '0;
        order    <= burstOrder_t'(burstIlv);
      end else if (curValid) begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  sramBurstSeq #(.ADDR_W(ADDR_W)) uSeq (
    .baseAddr (baseAddr),
    .count    (cnt),
    .order    (order),
    .seqAddr  (curAddr)
  );

  always_comb begin
    strobes.writePhase = curValid & curWrite;
    strobes.readPhase  = curValid & ~curWrite;
    strobes.commit     = curValid & curWrite & clkEn;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(curAddr) && $stable(strobes.readPhase) && $stable(strobes.writePhase)); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && advLoad && curValid && order == ORDER_LINEAR
    |=> curAddr[1:0] == $past(curAddr[1:0]) + 2'd1); // R9

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && advLoad && curValid
    |=> curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2])); // R9

  AST_DESELECT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && advLoad && !curValid |=> !strobes.readPhase && !strobes.writePhase); // R11

endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [LANES-1:0]        curLanes,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.commit && curLanes[g])
        laneMem[curAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign dOutEn = oe & strobes.readPhase;
  assign dOut   = dOutEn ? rdWord : '0;

  AST_NO_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writePhase |-> !dOutEn); // R7

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !oe |-> !dOutEn); // R8

  AST_COMMIT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> strobes.writePhase && !strobes.readPhase); // R4

endmodule

// File: rtl/flowSram.sv
module flowSram
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selA,
  input  logic                    selBN,
  input  logic                    selC,
  input  logic                    wrEn,
  input  logic [LANES-1:0]        laneWe,
  input  logic                    advLoad,
  input  logic                    burstIlv,
  input  logic                    oe,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] curAddr;
  logic [LANES-1:0]  curLanes;

  sramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .addr     (addr),
    .selA     (selA),
    .selBN    (selBN),
    .selC     (selC),
    .wrEn     (wrEn),
    .laneWe   (laneWe),
    .advLoad  (advLoad),
    .burstIlv (burstIlv),
    .strobes  (strobes),
    .curAddr  (curAddr),
    .curLanes (curLanes)
  );

  sramDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .curAddr  (curAddr),
    .curLanes (curLanes),
    .dIn      (dIn),
    .oe       (oe),
    .dOut     (dOut),
    .dOutEn   (dOutEn)
  );

endmodule

// File: tb/flowSram_test.sv
module flowSram_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic [5:0]  addr = '0;
  logic        selA = 1'b0;
  logic        selBN = 1'b1;
  logic        selC = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  laneWe = '0;
  logic        advLoad = 1'b0;
  logic        burstIlv = 1'b0;
  logic        oe = 1'b1;
  logic [35:0] dIn = '0;
  logic [35:0] dOut;
  logic        dOutEn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flowSram uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr),
    .selA(selA), .selBN(selBN), .selC(selC), .wrEn(wrEn),
    .laneWe(laneWe), .advLoad(advLoad), .burstIlv(burstIlv),
    .oe(oe), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  typedef struct packed {
    logic        adv;
    logic        wr;
    logic [2:0]  sel;   // {selA, selBN, selC}; 3'b101 selects
    logic [5:0]  a;
    logic [3:0]  lanes;
    logic [35:0] din;
    logic        expEn;
    logic [35:0] expD;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 1'b1, 3'b101, 6'h10, 4'hF, 36'h0,           1'b0, 36'h0},
    '{1'b0, 1'b1, 3'b101, 6'h11, 4'hF, 36'hF_FFFF_FFFF, 1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b101, 6'h10, 4'hF, 36'hA_5A5A_5A5A, 1'b1, 36'hF_FFFF_FFFF},
    '{1'b0, 1'b1, 3'b101, 6'h12, 4'hF, 36'h0,           1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b101, 6'h12, 4'hF, 36'h3_C3C3_C3C3, 1'b1, 36'h3_C3C3_C3C3},
    '{1'b0, 1'b0, 3'b101, 6'h11, 4'hF, 36'h0,           1'b1, 36'hA_5A5A_5A5A},
    '{1'b0, 1'b0, 3'b100, 6'h10, 4'hF, 36'h0,           1'b0, 36'h0},
    '{1'b0, 1'b1, 3'b101, 6'h10, 4'h5, 36'h0,           1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b101, 6'h10, 4'hF, 36'h0,           1'b1, 36'hF_F803_FE00},
    '{1'b0, 1'b1, 3'b111, 6'h12, 4'hF, 36'h0,           1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b101, 6'h12, 4'hF, 36'h1_2345_6789, 1'b1, 36'h3_C3C3_C3C3}
  };

  task automatic check(input string tag, input logic expEn, input logic [35:0] expD);
    checks++;
    if (dOutEn !== expEn) begin
      errors++;
      $display("FAIL %s: dOutEn=%b expected %b", tag, dOutEn, expEn);
    end else if (expEn && dOut !== expD) begin
      errors++;
      $display("FAIL %s: dOut=%h expected %h", tag, dOut, expD);
    end
  endtask

  task automatic step(input logic adv, input logic wr, input logic [2:0] sel,
                      input logic [5:0] a, input logic [3:0] ln, input logic [35:0] d,
                      input logic ilv, input logic ce);
    @(negedge clk);
    advLoad = adv; wrEn = wr; {selA, selBN, selC} = sel;
    addr = a; laneWe = ln; dIn = d; burstIlv = ilv; clkEn = ce;
    @(posedge clk);
    #1;
  endtask

  localparam logic [35:0] W0 = 36'h0_0000_00AA;
  localparam logic [35:0] W1 = 36'h0_0000_BB00;
  localparam logic [35:0] W2 = 36'h0_00CC_0000;
  localparam logic [35:0] W3 = 36'h0_DD00_0000;

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R12 during reset", 1'b0, 36'h0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R12 after reset", 1'b0, 36'h0);

    // R1 R3 R4 R5 R6 R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i].adv, TBL[i].wr, TBL[i].sel, TBL[i].a, TBL[i].lanes, TBL[i].din, 1'b0, 1'b1);
      check($sformatf("R1/R3/R4/R5/R6/R7 vector %0d", i), TBL[i].expEn, TBL[i].expD);
    end

    // R8: asynchronous output enable
    step(1'b0, 1'b0, 3'b101, 6'h11, 4'hF, 36'h0, 1'b0, 1'b1);
    check("R3 read before oe test", 1'b1, 36'hA_5A5A_5A5A);
    oe = 1'b0; #1;
    check("R8 oe low", 1'b0, 36'h0);
    oe = 1'b1; #1;
    check("R8 oe high again", 1'b1, 36'hA_5A5A_5A5A);

    // R2: stall during write data phase and during read
    step(1'b0, 1'b1, 3'b101, 6'h30, 4'hF, 36'h0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 3'b101, 6'h31, 4'hF, 36'h1_1111_1111, 1'b0, 1'b0);
    check("R2 stalled write phase", 1'b0, 36'h0);
    step(1'b0, 1'b0, 3'b101, 6'h30, 4'hF, 36'h2_4680_1357, 1'b0, 1'b1);
    check("R2 data after stall", 1'b1, 36'h2_4680_1357);
    step(1'b0, 1'b1, 3'b101, 6'h10, 4'hF, 36'h0, 1'b0, 1'b0);
    check("R2 output holds", 1'b1, 36'h2_4680_1357);

    // R9: linear write burst from 0x22, then linear read burst from 0x20
    step(1'b0, 1'b1, 3'b101, 6'h22, 4'hF, 36'h0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 3'b000, 6'h00, 4'hF, W0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 3'b000, 6'h00, 4'hF, W1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 3'b000, 6'h00, 4'hF, W2, 1'b1, 1'b1);
    step(1'b0, 1'b0, 3'b101, 6'h20, 4'hF, W3, 1'b0, 1'b1);
    check("R9 linear beat0 @20", 1'b1, W2);
    step(1'b1, 1'b1, 3'b000, 6'h3F, 4'hF, 36'h0, 1'b1, 1'b1);
    check("R9 linear beat1 @21", 1'b1, W3);
    step(1'b1, 1'b1, 3'b000, 6'h3F, 4'hF, 36'h0, 1'b1, 1'b1);
    check("R9 linear beat2 @22", 1'b1, W0);
    step(1'b1, 1'b1, 3'b000, 6'h3F, 4'hF, 36'h0, 1'b1, 1'b1);
    check("R9 linear beat3 @23", 1'b1, W1);

    // R10: interleaved read burst from 0x21 -> 21,20,23,22
    step(1'b0, 1'b0, 3'b101, 6'h21, 4'hF, 36'h0, 1'b1, 1'b1);
    check("R10 interleaved beat0 @21", 1'b1, W3);
    step(1'b1, 1'b0, 3'b101, 6'h00, 4'hF, 36'h0, 1'b0, 1'b1);
    check("R10 interleaved beat1 @20", 1'b1, W2);
    step(1'b1, 1'b0, 3'b101, 6'h00, 4'hF, 36'h0, 1'b0, 1'b1);
    check("R10 interleaved beat2 @23", 1'b1, W1);
    step(1'b1, 1'b0, 3'b101, 6'h00, 4'hF, 36'h0, 1'b0, 1'b1);
    check("R10 interleaved beat3 @22", 1'b1, W0);

    // R11: advance after deselect stays deselected, writes nothing
    step(1'b0, 1'b1, 3'b001, 6'h20, 4'hF, 36'h0, 1'b0, 1'b1);
    check("R11 deselect load", 1'b0, 36'h0);
    step(1'b1, 1'b1, 3'b101, 6'h21, 4'hF, 36'hF_0F0F_0F0F, 1'b0, 1'b1);
    check("R11 advance after deselect", 1'b0, 36'h0);
    step(1'b1, 1'b0, 3'b101, 6'h21, 4'hF, 36'hF_0F0F_0F0F, 1'b0, 1'b1);
    check("R11 second advance", 1'b0, 36'h0);
    step(1'b0, 1'b0, 3'b101, 6'h20, 4'hF, 36'hE_EEEE_EEEE, 1'b0, 1'b1);
    check("R11 word untouched", 1'b1, W2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule